// File: doc/BRIEF.md
# Pipelined Recursive Squarer with Table Leaves

This block returns the square of a 16-bit unsigned operand. It does not use a general multiplier for the square. It splits the operand into halves twice, so the recursion bottoms out at four 4-bit nibbles. Each nibble is squared by a constant 16-entry lookup table with an 8-bit result. At each level the two half-squares are joined through the identity (hi·2^k + lo)² = hi²·2^2k + 2·hi·lo·2^k + lo². The cross product hi·lo is a k-bit by k-bit multiply.

Register stages sit between the recursion levels. The first stage captures the four table lookups and the cross products, which act as the registered input. The second stage holds the two 8-bit-level squares. The third stage holds the 32-bit result. A valid bit travels alongside the data. An operand offered with `in_valid` high at a rising edge is answered three rising edges later. One operand can be accepted on every cycle.

Top module: `sq16_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_square` is 0.
- R2: For any 16-bit operand accepted with `in_valid` high, `out_square` equals the operand multiplied by itself, as an unsigned 32-bit value.
- R3: `out_valid` is high in exactly those cycles that follow the rising edge three edges after an edge at which `in_valid` was high.
- R4: Operands may arrive on consecutive cycles, and each one yields its own correct result on consecutive cycles.
- R5: An edge at which `in_valid` is low has no effect on the result. Three edges later `out_valid` is 0, and `out_square` still shows the last valid square (0 if none since reset).
- R6: Operands below 16 are squared exactly by the nibble table alone; for example, 3 gives 9 and 15 gives 225.
- R7: The largest operand, 0xFFFF, gives 0xFFFE0001, and no result ever exceeds that value.
- R8: Every operand from 0 to 255 gives its exact square, which covers the complete 8-bit recursion level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand qualifier, sampled each rising edge |
| in_operand | input | 16 | Unsigned operand to square |
| out_valid | output | 1 | High when `out_square` carries a new result |
| out_square | output | 32 | Square of the operand accepted three edges earlier |

## Verification
The bench drives each operand just after a falling edge, so the rising edge that follows captures it. The result of that operand is due after the third rising edge following the capture. The bench therefore keeps a three-deep history of what it drove and compares the outputs at every falling edge against the entry from three falling edges before. The comparison covers the square value, the valid bit, and the held value for idle slots. Because every idle slot is compared as well, a result that comes one cycle early or late shows up as a wrong valid bit.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int unsigned OP_W_DEF   = 16;
    localparam int unsigned LEAF_W_DEF = 4;
endpackage

// File: rtl/sq_leaf_rom.sv
module sq_leaf_rom (
    input  logic [3:0] idx,
    output logic [7:0] sq
);
    always_comb begin
        unique case (idx)
            4'd0:  sq = 8'd0;
            4'd1:  sq = 8'd1;
            4'd2:  sq = 8'd4;
            4'd3:  sq = 8'd9;
            4'd4:  sq = 8'd16;
            4'd5:  sq = 8'd25;
            4'd6:  sq = 8'd36;
            4'd7:  sq = 8'd49;
            4'd8:  sq = 8'd64;
            4'd9:  sq = 8'd81;
            4'd10: sq = 8'd100;
            4'd11: sq = 8'd121;
            4'd12: sq = 8'd144;
            4'd13: sq = 8'd169;
            4'd14: sq = 8'd196;
            4'd15: sq = 8'd225;
            default: sq = 8'd0;
        endcase
    end
endmodule

// File: rtl/sq_merge.sv
module sq_merge #(
    parameter int unsigned K = 4
) (
    input  logic [2*K-1:0] hi_sq,
    input  logic [2*K-1:0] lo_sq,
    input  logic [2*K-1:0] hi_lo,
    output logic [4*K-1:0] sq
);
    // (hi*2^K + lo)^2 = hi^2 << 2K + hi*lo << (K+1) + lo^2
    always_comb begin
        sq = {hi_sq, {(2*K){1'b0}}}
           + {{(K-1){1'b0}}, hi_lo, {(K+1){1'b0}}}
           + {{(2*K){1'b0}}, lo_sq};
    end
endmodule

// File: rtl/sq16_top.sv
module sq16_top #(
    parameter int unsigned OP_W   = sq_pkg::OP_W_DEF,
    parameter int unsigned LEAF_W = sq_pkg::LEAF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_operand,
    output logic              out_valid,
    output logic [2*OP_W-1:0] out_square
);
    localparam int unsigned MID_W = 2 * LEAF_W;
    localparam int unsigned NLEAF = OP_W / LEAF_W;
    localparam int unsigned NMID  = OP_W / MID_W;
    localparam int unsigned SQL_W = 2 * LEAF_W;
    localparam int unsigned SQM_W = 2 * MID_W;

    // ---- stage 1: leaf lookups and cross products -----------------
    logic [NLEAF-1:0][SQL_W-1:0] leaf_d, leaf_q;
    logic [NMID-1:0][MID_W-1:0]  xmid_d, xmid_q;
    logic [OP_W-1:0]             xtop_d, xtop_q;
    logic                        v1_q;

    genvar gi;
    generate
        for (gi = 0; gi < NLEAF; gi++) begin : g_leaf
            sq_leaf_rom u_rom (
                .idx (in_operand[gi*LEAF_W +: LEAF_W]),
                .sq  (leaf_d[gi])
            );
        end
        for (gi = 0; gi < NMID; gi++) begin : g_xmid
            assign xmid_d[gi] =
                {{LEAF_W{1'b0}}, in_operand[(2*gi+1)*LEAF_W +: LEAF_W]} *
                {{LEAF_W{1'b0}}, in_operand[(2*gi)*LEAF_W   +: LEAF_W]};
        end
    endgenerate

    assign xtop_d = {{MID_W{1'b0}}, in_operand[OP_W-1:MID_W]} *
                    {{MID_W{1'b0}}, in_operand[MID_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leaf_q <= '0;
            xmid_q <= '0;
            xtop_q <= '0;
            v1_q   <= 1'b0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                leaf_q <= leaf_d;
                xmid_q <= xmid_d;
                xtop_q <= xtop_d;
            end
        end
    end

    // ---- stage 2: join leaf pairs into mid-level squares ----------
    logic [NMID-1:0][SQM_W-1:0] mid_d, mid_q;
    logic [OP_W-1:0]            xtop2_q;
    logic                       v2_q;

    generate
        for (gi = 0; gi < NMID; gi++) begin : g_mid
            sq_merge #(.K(LEAF_W)) u_merge (
                .hi_sq (leaf_q[2*gi+1]),
                .lo_sq (leaf_q[2*gi]),
                .hi_lo (xmid_q[gi]),
                .sq    (mid_d[gi])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_q   <= '0;
            xtop2_q <= '0;
            v2_q    <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                mid_q   <= mid_d;
                xtop2_q <= xtop_q;
            end
        end
    end

    // ---- stage 3: join the two mid squares into the result --------
    logic [2*OP_W-1:0] top_d;

    sq_merge #(.K(MID_W)) u_top_merge (
        .hi_sq (mid_q[1]),
        .lo_sq (mid_q[0]),
        .hi_lo (xtop2_q),
        .sq    (top_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_square <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= v2_q;
            if (v2_q) begin
                out_square <= top_d;
            end
        end
    end
endmodule

// File: rtl/sq16_chk.sv
module sq16_chk #(
    parameter int unsigned OP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_operand,
    input logic              out_valid,
    input logic [2*OP_W-1:0] out_square
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (out_valid == 1'b0 && out_square == '0);
        end
    end

    p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_square_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid) |->
        (out_square == ({{OP_W{1'b0}}, $past(in_operand, 3)} *
                        {{OP_W{1'b0}}, $past(in_operand, 3)})));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |-> $stable(out_square));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_square <= {{(OP_W-1){1'b1}}, 1'b0, {(OP_W-1){1'b0}}, 1'b1});
endmodule

bind sq16_top sq16_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/sim_sq16_top.sv
`timescale 1ns/1ps
module sim_sq16_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_operand = '0;
    logic        out_valid;
    logic [31:0] out_square;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic        h_v  [3];
    logic [15:0] h_op [3];
    string       h_tag[3];
    logic [31:0] last_sq = '0;

    always #5 clk = ~clk;

    sq16_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_operand(in_operand), .out_valid(out_valid), .out_square(out_square)
    );

    // One cycle: check the entry driven three falling edges ago, then drive.
    task automatic step(input logic v, input logic [15:0] op, input string tag);
        logic [31:0] exp_sq;
        logic        exp_v;
        @(negedge clk);
        exp_v  = h_v[2];
        exp_sq = h_v[2] ? ({16'b0, h_op[2]} * {16'b0, h_op[2]}) : last_sq;
        n_vec++;
        if (out_valid !== exp_v || out_square !== exp_sq) begin
            n_bad++;
            $display("FAIL %s op=%h: valid=%b square=%h expected valid=%b square=%h",
                     h_v[2] ? h_tag[2] : "R5", h_op[2], out_valid, out_square,
                     exp_v, exp_sq);
        end
        if (h_v[2]) last_sq = exp_sq;
        h_v[2] = h_v[1]; h_op[2] = h_op[1]; h_tag[2] = h_tag[1];
        h_v[1] = h_v[0]; h_op[1] = h_op[0]; h_tag[1] = h_tag[0];
        h_v[0] = v;      h_op[0] = op;      h_tag[0] = tag;
        in_valid   = v;
        in_operand = op;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            h_v[i] = 1'b0; h_op[i] = '0; h_tag[i] = "R3";
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (out_valid !== 1'b0 || out_square !== 32'h0) begin
            n_bad++;
            $display("FAIL R1: valid=%b square=%h expected valid=0 square=0",
                     out_valid, out_square);
        end
        rst_n = 1'b1;

        // R3 / R5: idle slots right after reset, then a lone pulse
        for (int i = 0; i < 3; i++) step(1'b0, 16'h1234, "R5");
        step(1'b1, 16'h0007, "R3");
        for (int i = 0; i < 4; i++) step(1'b0, 16'hBEEF, "R5");

        // R6: nibble-only operands, back to back (R4)
        for (int i = 0; i < 16; i++) step(1'b1, 16'(i), "R6");

        // R8: full 8-bit sweep with a bubble every seventh slot (R5)
        for (int i = 0; i < 256; i++) begin
            if (i % 7 == 3) step(1'b0, 16'hFFFF, "R5");
            step(1'b1, 16'(i), "R8");
        end

        // R7: extremes and half boundaries
        step(1'b1, 16'hFFFF, "R7");
        step(1'b1, 16'h8000, "R7");
        step(1'b1, 16'hFF00, "R7");
        step(1'b1, 16'h00FF, "R7");
        step(1'b1, 16'h0F0F, "R7");
        step(1'b1, 16'hFFFF, "R7");

        // R2 / R4: random operands, mostly back to back
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 5) == 0) step(1'b0, 16'($urandom), "R5");
            else                     step(1'b1, 16'($urandom), "R2");
        end

        // R4: a long unbroken burst
        for (int i = 0; i < 64; i++) step(1'b1, 16'(i * 1021 + 7), "R4");

        for (int i = 0; i < 4; i++) step(1'b0, 16'h0000, "R5");
        finish_run();
    end
endmodule